// File: doc/BRIEF.md
# Region-Based Bus Clock Stretcher

This block produces the processor bus clock for a small 8-bit system from a fast master clock. The bus clock normally runs at the rate the static RAM allows. Each bus cycle is compared against a fixed address map when it begins. A cycle that lands in the boot ROM window or the I/O window runs at half that rate, and every other cycle keeps full speed. The ROM window covers the top of memory, where the reset and interrupt vectors live, so vector fetches are always stretched.

The base rate is set by a counter divider. A 2-bit rate select gives a half-period of 1, 2, 4 or 8 master cycles. After reset the slowest setting is active. Software changes the rate through a one-cycle write strobe, and the new rate takes effect at the next cycle boundary. The block also reports the region of the cycle in progress and keeps a running count of stretched cycles.

Top module: `busclk_stretch`

## Requirements
- R1: While reset is asserted, cpuClk is high, regionCode is 0 and stretchCount is 0. The first high phase after reset release lasts 8 master cycles.
- R2: A rate select value n (0..3) makes each phase of a full-speed cycle last 2^n master cycles. The value is written with rateWe and rateIn.
- R3: After reset the rate select is 3, the slowest setting, until it is written.
- R4: A cycle whose address is at or above 0xE000 is a ROM cycle. This window includes the vectors at 0xFFFA-0xFFFF. Both phases of a ROM cycle last twice the full-speed length.
- R5: A cycle whose address is in 0xC000-0xC0FF is an I/O cycle and is stretched the same way. Addresses 0xC100 and 0xBFFF are not stretched.
- R6: A cycle that starts with cycValid low runs at full speed and reports regionCode 0, whatever the address.
- R7: The address and cycValid are sampled only at the master edge where cpuClk falls, which is the start of a cycle. A change after that edge does not affect the cycle in progress.
- R8: regionCode is 0 for RAM, 1 for ROM and 2 for I/O. It holds one value from one falling edge of cpuClk to the next.
- R9: stretchCount rises by exactly one at the start of each stretched cycle and does not change at any other time.
- R10: cpuClk changes only on master rising edges. Both phases of a cycle have the same length, and no phase is longer than 16 master cycles.
- R11: A rate write made during a cycle leaves that cycle's phase lengths unchanged. The new rate applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 16 | Processor address |
| cycValid | input | 1 | Address marks a real bus access |
| rateWe | input | 1 | One-cycle strobe that loads rateIn |
| rateIn | input | 2 | New rate select, half-period 2^rateIn |
| cpuClk | output | 1 | Stretched processor bus clock |
| regionCode | output | 2 | Region of the current cycle: 0 RAM, 1 ROM, 2 I/O |
| stretchCount | output | 16 | Number of stretched cycles since reset |

## Verification
A corrupted phase counter or latched rate appears within one bus cycle as a low or high phase of the wrong length. The monitor measures every phase to the master cycle, so it catches this on the cycle after the fault. A wrong latched region shows up at the same fall as a bad regionCode and an off-by-one stretchCount, and the phase length is wrong too. A decode that samples the address late is exposed because the driver changes the address right after each cycle begins. The bench also switches rate mid-cycle, which shows whether a rate change is applied early or late.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  typedef enum logic [1:0] {
    REG_SRAM = 2'd0,
    REG_ROM  = 2'd1,
    REG_IO   = 2'd2
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseEnd;    // current phase is in its last master cycle
    logic cycleStart;  // high phase ends here: a new bus cycle begins
  } phaseStrobe_t;
endpackage

// File: rtl/busclk_ctrl.sv
module busclk_ctrl
  import busclk_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuClk,
  input  logic [RATE_W-1:0] curRate,
  input  logic              curSlow,
  output phaseStrobe_t      strobes
);
  localparam int CNT_W = 1 << RATE_W;  // longest phase is 2^(2^RATE_W) cycles
  localparam logic [CNT_W:0] LEN_ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] phaseCnt;
  logic [RATE_W:0]  shiftAmt;
  logic [CNT_W:0]   phaseLen;

  always_comb begin
    shiftAmt = {1'b0, curRate} + {{RATE_W{1'b0}}, curSlow};
    phaseLen = LEN_ONE << shiftAmt;
    strobes.phaseEnd   = ({1'b0, phaseCnt} == (phaseLen - LEN_ONE));
    strobes.cycleStart = strobes.phaseEnd & cpuClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else if (strobes.phaseEnd) phaseCnt <= '0;
    else phaseCnt <= phaseCnt + 1'b1;
  end
endmodule

// File: rtl/busclk_datapath.sv
module busclk_datapath
  import busclk_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          RATE_W    = 2,
  parameter int          COUNT_W   = 16,
  parameter logic [15:0] ROM_BASE  = 16'hE000,
  parameter logic [15:0] IO_BASE   = 16'hC000,
  parameter logic [15:0] IO_MASK   = 16'hFF00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               cycValid,
  input  logic               rateWe,
  input  logic [RATE_W-1:0]  rateIn,
  input  phaseStrobe_t       strobes,
  output logic               cpuClk,
  output logic [RATE_W-1:0]  curRate,
  output logic               curSlow,
  output logic [1:0]         regionCode,
  output logic [COUNT_W-1:0] stretchCount
);
  localparam logic [RATE_W-1:0] RATE_SLOWEST = '1;

  logic [RATE_W-1:0] rateSel;
  region_e           regionQ;
  region_e           regionNext;
  logic              romHit;
  logic              ioHit;

  always_comb begin
    romHit = busAddr >= ADDR_W'(ROM_BASE);
    ioHit  = (busAddr & ADDR_W'(IO_MASK)) == ADDR_W'(IO_BASE);
    if (!cycValid)   regionNext = REG_SRAM;
    else if (romHit) regionNext = REG_ROM;
    else if (ioHit)  regionNext = REG_IO;
    else             regionNext = REG_SRAM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rateSel <= RATE_SLOWEST;
    else if (rateWe) rateSel <= rateIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClk       <= 1'b1;
      curRate      <= RATE_SLOWEST;
      regionQ      <= REG_SRAM;
      stretchCount <= '0;
    end else begin
      if (strobes.phaseEnd) cpuClk <= ~cpuClk;
      if (strobes.cycleStart) begin
        curRate <= rateSel;
        regionQ <= regionNext;
        if (regionNext != REG_SRAM) stretchCount <= stretchCount + 1'b1;
      end
    end
  end

  assign curSlow    = (regionQ != REG_SRAM);
  assign regionCode = regionQ;
endmodule

// File: rtl/busclk_stretch.sv
module busclk_stretch
  import busclk_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          RATE_W   = 2,
  parameter int          COUNT_W  = 16,
  parameter logic [15:0] ROM_BASE = 16'hE000,
  parameter logic [15:0] IO_BASE  = 16'hC000,
  parameter logic [15:0] IO_MASK  = 16'hFF00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               cycValid,
  input  logic               rateWe,
  input  logic [RATE_W-1:0]  rateIn,
  output logic               cpuClk,
  output logic [1:0]         regionCode,
  output logic [COUNT_W-1:0] stretchCount
);
  phaseStrobe_t      strobes;
  logic [RATE_W-1:0] curRate;
  logic              curSlow;

  busclk_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuClk(cpuClk),
    .curRate(curRate), .curSlow(curSlow), .strobes(strobes)
  );

  busclk_datapath #(
    .ADDR_W(ADDR_W), .RATE_W(RATE_W), .COUNT_W(COUNT_W),
    .ROM_BASE(ROM_BASE), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .cycValid(cycValid),
    .rateWe(rateWe), .rateIn(rateIn), .strobes(strobes),
    .cpuClk(cpuClk), .curRate(curRate), .curSlow(curSlow),
    .regionCode(regionCode), .stretchCount(stretchCount)
  );
endmodule

// File: rtl/busclk_stretch_chk.sv
module busclk_stretch_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          RATE_W   = 2,
  parameter int          COUNT_W  = 16,
  parameter logic [15:0] ROM_BASE = 16'hE000,
  parameter logic [15:0] IO_BASE  = 16'hC000,
  parameter logic [15:0] IO_MASK  = 16'hFF00
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               cycValid,
  input logic               cpuClk,
  input logic [1:0]         regionCode,
  input logic [COUNT_W-1:0] stretchCount
);
  localparam int MAX_PHASE = 2 << ((1 << RATE_W) - 1);
  localparam int AGE_W     = $clog2(MAX_PHASE) + 2;
  localparam logic [AGE_W-1:0] AGE_TOP = '1;

  logic             prevClk;
  logic [AGE_W-1:0] phaseAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b1;
      phaseAge <= '0;
    end else begin
      prevClk <= cpuClk;
      if (cpuClk != prevClk) phaseAge <= '0;
      else if (phaseAge != AGE_TOP) phaseAge <= phaseAge + 1'b1;
    end
  end

  // R10: no phase outlasts the longest legal stretched phase
  p_phase_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    phaseAge <= AGE_W'(MAX_PHASE));

  // R8: region holds except at a falling edge of cpuClk
  p_region_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !($past(cpuClk) && !cpuClk) |-> $stable(regionCode));

  // R9: count moves only at a cycle start, and by one
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stretchCount) |-> ($past(cpuClk) && !cpuClk &&
      (stretchCount == $past(stretchCount) + 1'b1)));

  // R6: a cycle started without a valid access is a RAM-speed cycle
  p_idle_fast_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuClk) && !cpuClk && !$past(cycValid)) |-> (regionCode == 2'd0));

  // R4: valid access in the top window reports ROM
  p_rom_region_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuClk) && !cpuClk && $past(cycValid) &&
     ($past(busAddr) >= ADDR_W'(ROM_BASE))) |-> (regionCode == 2'd1));

  // R5: stretched phases never last a single master cycle
  p_slow_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((regionCode != 2'd0) && !$past(cpuClk) && cpuClk) |=> cpuClk);
endmodule

bind busclk_stretch busclk_stretch_chk #(
  .ADDR_W(ADDR_W), .RATE_W(RATE_W), .COUNT_W(COUNT_W),
  .ROM_BASE(ROM_BASE), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .cycValid(cycValid),
  .cpuClk(cpuClk), .regionCode(regionCode), .stretchCount(stretchCount)
);

// File: tb/sim_busclk_stretch.sv
module sim_busclk_stretch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        cycValid = 1'b0;
  logic        rateWe = 1'b0;
  logic [1:0]  rateIn = 2'd0;
  logic        cpuClk;
  logic [1:0]  regionCode;
  logic [15:0] stretchCount;

  always #2.5 clk = ~clk;  // 200 MHz

  busclk_stretch u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .cycValid(cycValid),
    .rateWe(rateWe), .rateIn(rateIn), .cpuClk(cpuClk),
    .regionCode(regionCode), .stretchCount(stretchCount)
  );

  typedef struct {
    int    phaseN;
    int    region;
    int    cnt;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int applied = 0;
  int failed = 0;
  int modelRate = 3;
  int expCnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    applied++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  endtask

  // driver: sets stimulus for the next cycle, then pushes its expectation
  task automatic doCycle(input logic [15:0] a, input logic v, input bit wr,
                         input int r, input string tag);
    int reg_;
    int slow;
    expItem_t it;
    busAddr  = a;
    cycValid = v;
    if (wr) begin
      rateIn = 2'(r);
      rateWe = 1'b1;
      @(negedge clk);
      rateWe = 1'b0;
    end
    @(negedge cpuClk);
    @(negedge clk);
    if (wr) modelRate = r;
    if (!v) reg_ = 0;
    else if (a >= 16'hE000) reg_ = 1;
    else if (a[15:8] == 8'hC0) reg_ = 2;
    else reg_ = 0;
    slow = (reg_ != 0) ? 1 : 0;
    expCnt += slow;
    it.phaseN = (1 << modelRate) << slow;
    it.region = reg_;
    it.cnt    = expCnt;
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  // monitor: measures each cycle from one falling edge to the next
  initial begin
    bit prevC = 1'b1;
    bit started = 1'b0;
    int lowN = 0;
    int highN = 0;
    int startReg = 0;
    int startCnt = 0;
    expItem_t it;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (prevC && !cpuClk) begin
        if (!started) begin
          // R1 R3: 8-cycle first phase, 7 samples after release
          chk(highN == 7, "R1", "first high phase samples", highN, 7);
          started = 1'b1;
        end else if (expQ.size() > 0) begin
          it = expQ.pop_front();
          chk(lowN == it.phaseN, it.tag, "low phase", lowN, it.phaseN);
          chk(highN == it.phaseN, it.tag, "high phase (R10)", highN, it.phaseN);
          chk(startReg == it.region, it.tag, "regionCode (R8)", startReg, it.region);
          chk(startCnt == it.cnt, it.tag, "stretchCount (R9)", startCnt, it.cnt);
        end
        lowN = 1;
        highN = 0;
        startReg = int'(regionCode);
        startCnt = int'(stretchCount);
      end else if (cpuClk) highN++;
      else lowN++;
      prevC = cpuClk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpuClk == 1'b1, "R1", "cpuClk in reset", int'(cpuClk), 1);
    chk(regionCode == 2'd0, "R1", "regionCode in reset", int'(regionCode), 0);
    chk(stretchCount == 16'd0, "R1", "stretchCount in reset", int'(stretchCount), 0);
    rstN = 1'b1;
    // R3: default slowest rate, RAM cycle
    doCycle(16'h1000, 1'b1, 1'b0, 0, "R3");
    // R4: ROM window and reset vector
    doCycle(16'hE000, 1'b1, 1'b0, 0, "R4");
    doCycle(16'hFFFC, 1'b1, 1'b0, 0, "R4");
    // R5: I/O window and its edges
    doCycle(16'hC010, 1'b1, 1'b0, 0, "R5");
    doCycle(16'hC0FF, 1'b1, 1'b0, 0, "R5");
    doCycle(16'hC100, 1'b1, 1'b0, 0, "R5");
    doCycle(16'hBFFF, 1'b1, 1'b0, 0, "R5");
    // R6: invalid cycle on a ROM address
    doCycle(16'hFFFE, 1'b0, 1'b0, 0, "R6");
    // R2 R11: rate writes land mid-cycle, apply from next cycle
    doCycle(16'h0200, 1'b1, 1'b1, 0, "R11");
    doCycle(16'hFFFA, 1'b1, 1'b0, 0, "R2");
    doCycle(16'h0300, 1'b1, 1'b1, 1, "R2");
    doCycle(16'hC000, 1'b1, 1'b0, 0, "R2");
    doCycle(16'hDFFF, 1'b1, 1'b1, 2, "R2");
    doCycle(16'hFFFF, 1'b1, 1'b0, 0, "R4");
    // R7: every cycle above already moved the address right after its start
    doCycle(16'hC080, 1'b0, 1'b1, 0, "R7");
    doCycle(16'hE123, 1'b1, 1'b0, 0, "R7");
    doCycle(16'h0000, 1'b1, 1'b0, 0, "R2");
    doCycle(16'h0000, 1'b1, 1'b0, 0, "R2");
    repeat (4) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule